// File: doc/BRIEF.md
# Memory-mapped register agent with error responses

This block is a small register file that sits behind a single-word memory-mapped agent port. The port uses a stall handshake: the requester raises a read or write strobe together with a word address, and holds it until the agent drops its stall signal. Each accepted transfer gets exactly one response cycle. A read completes with a data-valid strobe. A write completes with a separate write-acknowledge strobe. A two-bit status code comes with each response.

The register set holds two read-write words (a control word that is also driven out of the block, and a scratch word), two read-only words (a live hardware status input and a build-time identity constant), and one write-only command word that is driven out of the block. Two build-time switches decide what goes back for faulty accesses. The first flags any access to a word that holds no register. The second flags a read of the write-only word or a write to a read-only word. The two switches act independently. A faulty write never changes any storage. A read that cannot return data returns zeros.

Top module: `regmm_agent`

## Requirements
- R1: A transfer is accepted on a rising edge where `mm_read` or `mm_write` is high and `mm_wait` is low. `mm_wait` is high exactly in the cycle after an acceptance and low in every other cycle out of reset. A request held through that cycle is therefore accepted on the following edge.
- R2: The cycle after an acceptance carries exactly one response strobe: `mm_rvalid` for a read, `mm_bvalid` for a write. Both strobes are low in every other cycle and are never high together.
- R3: When `mm_read` and `mm_write` are both high at acceptance, the transfer is a write.
- R4: Word map: word 0 is the control word (read-write, drives `ctrl_out`), word 1 is scratch (read-write), word 2 returns `status_in` as sampled at acceptance (read-only), word 3 returns `ID_VALUE` (read-only), and word 4 is the command word (write-only, drives `cmd_out`). Words 5 and above are unmapped.
- R5: In a write, byte lane i (bits 8i+7 down to 8i) of the target word takes the same lane of `mm_wdata` only when `mm_be[i]` is 1. All other lanes keep their value.
- R6: `mm_resp` is 2'b00 for a normal completion and 2'b10 for an error. It is 2'b00 in every cycle without a response strobe.
- R7: An access to an unmapped word responds 2'b10 when `ERR_BAD_ADDR` is 1 and 2'b00 when it is 0.
- R8: A read of the write-only word or a write to a read-only word responds 2'b10 when `ERR_BAD_DIR` is 1 and 2'b00 when it is 0.
- R9: A write to a read-only or unmapped word leaves every stored word, `ctrl_out` and `cmd_out` unchanged, whatever the switch settings.
- R10: A read of an unmapped word or of the write-only word returns all-zero `mm_rdata`. `mm_rdata` is zero in every cycle without `mm_rvalid`.
- R11: A synchronous active-high `rst` clears the control, scratch and command words, both response strobes, `mm_wait` and `mm_resp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mm_read | input | 1 | Read request strobe |
| mm_write | input | 1 | Write request strobe |
| mm_wait | output | 1 | Stall: request not taken this cycle |
| mm_addr | input | ADDR_W | Word address (byte address shifted right by log2 of bytes per word) |
| mm_wdata | input | DATA_W | Write data |
| mm_be | input | DATA_W/8 | Per-byte write enables |
| mm_rvalid | output | 1 | Read response strobe |
| mm_bvalid | output | 1 | Write acknowledge strobe |
| mm_rdata | output | DATA_W | Read data, valid with `mm_rvalid` |
| mm_resp | output | 2 | Response code: 00 normal, 10 error |
| status_in | input | DATA_W | Live value behind the status word |
| ctrl_out | output | DATA_W | Current control word |
| cmd_out | output | DATA_W | Current command word |

## Verification
The bench builds four copies side by side, one for each setting of `ERR_BAD_ADDR` and `ERR_BAD_DIR` (00, 01, 10, 11), and drives all four with the same stimulus. The same faulty access therefore shows up as an error in some copies and as a normal completion in the others in the same cycle, so each switch is shown to act alone. Because the stored contents must agree across all four copies, the test also shows that rejected writes change nothing no matter how the switches are set.

// File: rtl/regmm_pkg.sv
package regmm_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_RW   = 2'd1,
    KIND_RO   = 2'd2,
    KIND_WO   = 2'd3
  } kind_t;

  // word indices; the order is the software-visible map
  localparam int unsigned W_CTRL    = 0;
  localparam int unsigned W_SCRATCH = 1;
  localparam int unsigned W_STATUS  = 2;
  localparam int unsigned W_IDENT   = 3;
  localparam int unsigned W_CMD     = 4;

  // storage slots for the words that can be written
  localparam int unsigned N_SLOTS      = 3;
  localparam int          SLOT_CTRL    = 0;
  localparam int          SLOT_SCRATCH = 1;
  localparam int          SLOT_CMD     = 2;
  localparam int          SLOT_NONE    = -1;

  localparam logic [1:0] RSP_OKAY = 2'b00;
  localparam logic [1:0] RSP_ERR  = 2'b10;

  function automatic kind_t kind_of(input int unsigned widx);
    case (widx)
      W_CTRL, W_SCRATCH: return KIND_RW;
      W_STATUS, W_IDENT: return KIND_RO;
      W_CMD:             return KIND_WO;
      default:           return KIND_NONE;
    endcase
  endfunction

  function automatic int slot_of(input int unsigned widx);
    case (widx)
      W_CTRL:    return SLOT_CTRL;
      W_SCRATCH: return SLOT_SCRATCH;
      W_CMD:     return SLOT_CMD;
      default:   return SLOT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/regmm_decode.sv
module regmm_decode
  import regmm_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter bit          ERR_BAD_ADDR = 1'b1,
  parameter bit          ERR_BAD_DIR  = 1'b1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_write,
  output logic               unmapped,
  output logic               dir_bad,
  output logic               err,
  output logic               read_ok,
  output logic [N_SLOTS-1:0] wr_slot
);

  kind_t kind;

  always_comb begin
    kind     = kind_of(32'(addr));
    unmapped = (kind == KIND_NONE);
    dir_bad  = is_write ? (kind == KIND_RO) : (kind == KIND_WO);
    err      = (unmapped && ERR_BAD_ADDR) || (dir_bad && ERR_BAD_DIR);
    read_ok  = !is_write && (kind == KIND_RW || kind == KIND_RO);
    for (int s = 0; s < int'(N_SLOTS); s++) begin
      wr_slot[s] = is_write && (kind == KIND_RW || kind == KIND_WO)
                   && (slot_of(32'(addr)) == s);
    end
  end

endmodule

// File: rtl/regmm_store.sv
module regmm_store
  import regmm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_SLOTS-1:0]             wr_en,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [DATA_W/8-1:0]            be,
  output logic [N_SLOTS-1:0][DATA_W-1:0] slot_q
);

  localparam int unsigned N_LANES = DATA_W / 8;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    for (genvar b = 0; b < N_LANES; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst)                   lane_q <= '0;
        else if (wr_en[s] && be[b]) lane_q <= wdata[b*8 +: 8];
      end
      assign slot_q[s][b*8 +: 8] = lane_q;
    end
  end

endmodule

// File: rtl/regmm_resp.sv
module regmm_resp
  import regmm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              is_write,
  input  logic              err,
  input  logic [DATA_W-1:0] rdata_next,
  output logic              rvalid,
  output logic              bvalid,
  output logic [1:0]        resp,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      bvalid <= 1'b0;
      resp   <= RSP_OKAY;
      rdata  <= '0;
    end else begin
      rvalid <= acc && !is_write;
      bvalid <= acc && is_write;
      resp   <= (acc && err) ? RSP_ERR : RSP_OKAY;
      rdata  <= (acc && !is_write) ? rdata_next : '0;
    end
  end

  assign busy = rvalid || bvalid;

endmodule

// File: rtl/regmm_agent.sv
module regmm_agent
  import regmm_pkg::*;
#(
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       ADDR_W       = 4,
  parameter bit                ERR_BAD_ADDR = 1'b1,
  parameter bit                ERR_BAD_DIR  = 1'b1,
  parameter logic [DATA_W-1:0] ID_VALUE     = DATA_W'(32'h5EC7_0001)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mm_read,
  input  logic                mm_write,
  output logic                mm_wait,
  input  logic [ADDR_W-1:0]   mm_addr,
  input  logic [DATA_W-1:0]   mm_wdata,
  input  logic [DATA_W/8-1:0] mm_be,
  output logic                mm_rvalid,
  output logic                mm_bvalid,
  output logic [DATA_W-1:0]   mm_rdata,
  output logic [1:0]          mm_resp,
  input  logic [DATA_W-1:0]   status_in,
  output logic [DATA_W-1:0]   ctrl_out,
  output logic [DATA_W-1:0]   cmd_out
);

  // named internal events (observed by the bound checker)
  logic acc_evt;
  logic unmapped_evt;
  logic dirbad_evt;
  logic commit_evt;

  logic                           dec_err;
  logic                           dec_read_ok;
  logic [N_SLOTS-1:0]             dec_wr_slot;
  logic [N_SLOTS-1:0]             wr_en;
  logic [N_SLOTS-1:0][DATA_W-1:0] slot_q;
  logic [DATA_W-1:0]              rdata_next;
  logic                           busy;

  function automatic logic [DATA_W-1:0] pick_read(
    input logic [ADDR_W-1:0]              a,
    input logic                           ok,
    input logic [N_SLOTS-1:0][DATA_W-1:0] s,
    input logic [DATA_W-1:0]              st
  );
    if (!ok) return '0;
    case (32'(a))
      W_CTRL:    return s[SLOT_CTRL];
      W_SCRATCH: return s[SLOT_SCRATCH];
      W_STATUS:  return st;
      W_IDENT:   return ID_VALUE;
      default:   return '0;
    endcase
  endfunction

  assign acc_evt    = (mm_read || mm_write) && !busy;
  assign wr_en      = dec_wr_slot & {N_SLOTS{acc_evt}};
  assign commit_evt = |wr_en;
  assign rdata_next = pick_read(mm_addr, dec_read_ok, slot_q, status_in);

  regmm_decode #(
    .ADDR_W      (ADDR_W),
    .ERR_BAD_ADDR(ERR_BAD_ADDR),
    .ERR_BAD_DIR (ERR_BAD_DIR)
  ) u_decode (
    .addr    (mm_addr),
    .is_write(mm_write),
    .unmapped(unmapped_evt),
    .dir_bad (dirbad_evt),
    .err     (dec_err),
    .read_ok (dec_read_ok),
    .wr_slot (dec_wr_slot)
  );

  regmm_store #(
    .DATA_W(DATA_W)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .wdata (mm_wdata),
    .be    (mm_be),
    .slot_q(slot_q)
  );

  regmm_resp #(
    .DATA_W(DATA_W)
  ) u_resp (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc_evt),
    .is_write  (mm_write),
    .err       (dec_err),
    .rdata_next(rdata_next),
    .rvalid    (mm_rvalid),
    .bvalid    (mm_bvalid),
    .resp      (mm_resp),
    .rdata     (mm_rdata),
    .busy      (busy)
  );

  assign mm_wait  = busy;
  assign ctrl_out = slot_q[SLOT_CTRL];
  assign cmd_out  = slot_q[SLOT_CMD];

endmodule

// File: rtl/regmm_agent_chk.sv
module regmm_agent_chk
  import regmm_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter bit          ERR_BAD_ADDR = 1'b1,
  parameter bit          ERR_BAD_DIR  = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              mm_write,
  input logic              mm_wait,
  input logic              mm_rvalid,
  input logic              mm_bvalid,
  input logic [DATA_W-1:0] mm_rdata,
  input logic [1:0]        mm_resp,
  input logic [DATA_W-1:0] ctrl_out,
  input logic [DATA_W-1:0] cmd_out,
  input logic              acc_evt,
  input logic              unmapped_evt,
  input logic              dirbad_evt,
  input logic              commit_evt
);

  localparam logic [1:0] ADDR_CODE = ERR_BAD_ADDR ? RSP_ERR : RSP_OKAY;
  localparam logic [1:0] DIR_CODE  = ERR_BAD_DIR  ? RSP_ERR : RSP_OKAY;

  p_stall_in_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    (mm_rvalid || mm_bvalid) |-> mm_wait);

  p_no_back_to_back_r1: assert property (@(posedge clk) disable iff (rst)
    (mm_rvalid || mm_bvalid) |=> !(mm_rvalid || mm_bvalid));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !(mm_rvalid && mm_bvalid));

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    acc_evt |=> (mm_rvalid || mm_bvalid));

  p_write_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_evt && mm_write) |=> mm_bvalid);

  p_code_legal_r6: assert property (@(posedge clk) disable iff (rst)
    (mm_resp == RSP_OKAY) || (mm_resp == RSP_ERR));

  p_idle_code_r6: assert property (@(posedge clk) disable iff (rst)
    !(mm_rvalid || mm_bvalid) |-> (mm_resp == RSP_OKAY));

  p_unmapped_code_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_evt && unmapped_evt) |=> (mm_resp == ADDR_CODE));

  p_direction_code_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_evt && dirbad_evt) |=> (mm_resp == DIR_CODE));

  p_reject_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_evt && mm_write && !commit_evt) |=> ($stable(ctrl_out) && $stable(cmd_out)));

  p_idle_data_r10: assert property (@(posedge clk) disable iff (rst)
    !mm_rvalid |-> (mm_rdata == '0));

endmodule

bind regmm_agent regmm_agent_chk #(
  .DATA_W      (DATA_W),
  .ERR_BAD_ADDR(ERR_BAD_ADDR),
  .ERR_BAD_DIR (ERR_BAD_DIR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mm_write    (mm_write),
  .mm_wait     (mm_wait),
  .mm_rvalid   (mm_rvalid),
  .mm_bvalid   (mm_bvalid),
  .mm_rdata    (mm_rdata),
  .mm_resp     (mm_resp),
  .ctrl_out    (ctrl_out),
  .cmd_out     (cmd_out),
  .acc_evt     (acc_evt),
  .unmapped_evt(unmapped_evt),
  .dirbad_evt  (dirbad_evt),
  .commit_evt  (commit_evt)
);

// File: tb/test_regmm_agent.sv
`timescale 1ns/1ps
module test_regmm_agent;

  localparam logic [31:0] ID_VAL = 32'h5EC7_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] status_i = 32'h0BAD_F00D;

  logic [3:0]  wait_o, rv_o, bv_o;
  logic [31:0] rd_o   [4];
  logic [1:0]  rsp_o  [4];
  logic [31:0] ctrl_o [4];
  logic [31:0] cmd_o  [4];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  always #5 clk = ~clk;

  // config g: ERR_BAD_ADDR = g[1], ERR_BAD_DIR = g[0]
  for (genvar g = 0; g < 4; g++) begin : cfg
    regmm_agent #(
      .ERR_BAD_ADDR(((g >> 1) & 1) != 0),
      .ERR_BAD_DIR ((g & 1) != 0)
    ) i_regmm_agent (
      .clk      (clk),
      .rst      (rst),
      .mm_read  (rd_i),
      .mm_write (wr_i),
      .mm_wait  (wait_o[g]),
      .mm_addr  (addr_i),
      .mm_wdata (wdata_i),
      .mm_be    (be_i),
      .mm_rvalid(rv_o[g]),
      .mm_bvalid(bv_o[g]),
      .mm_rdata (rd_o[g]),
      .mm_resp  (rsp_o[g]),
      .status_in(status_i),
      .ctrl_out (ctrl_o[g]),
      .cmd_out  (cmd_o[g])
    );
  end

  task automatic check(input bit ok, input string tag, input int g,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cfg%0d actual=%h expected=%h at %0t", tag, g, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_ctrl, m_scr, m_cmd, m_rd;
  logic        m_busy, m_rv, m_bv;
  logic [1:0]  m_rsp [4];

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    bit acc, bad_a, bad_d;
    int w;
    if (rst) begin
      m_ctrl = '0; m_scr = '0; m_cmd = '0; m_rd = '0;
      m_busy = 0; m_rv = 0; m_bv = 0;
      for (int g = 0; g < 4; g++) m_rsp[g] = 2'b00;
    end else begin
      acc = (rd_i || wr_i) && !m_busy;
      m_rv = 0; m_bv = 0; m_rd = '0;
      for (int g = 0; g < 4; g++) m_rsp[g] = 2'b00;
      if (acc) begin
        w = int'(addr_i);
        bad_a = (w > 4);
        if (wr_i) begin
          m_bv = 1;
          bad_d = (w == 2 || w == 3);
          if (w == 0) m_ctrl = merge(m_ctrl, wdata_i, be_i);
          if (w == 1) m_scr  = merge(m_scr,  wdata_i, be_i);
          if (w == 4) m_cmd  = merge(m_cmd,  wdata_i, be_i);
        end else begin
          m_rv = 1;
          bad_d = (w == 4);
          case (w)
            0: m_rd = m_ctrl;
            1: m_rd = m_scr;
            2: m_rd = status_i;
            3: m_rd = ID_VAL;
            default: m_rd = '0;
          endcase
        end
        for (int g = 0; g < 4; g++)
          m_rsp[g] = ((bad_a && g[1]) || (bad_d && g[0])) ? 2'b10 : 2'b00;
      end
      m_busy = acc;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (live && !rst) begin
      for (int g = 0; g < 4; g++) begin
        check(wait_o[g] === m_busy, "R1 stall", g, 32'(wait_o[g]), 32'(m_busy));
        check(rv_o[g] === m_rv, "R2 read strobe", g, 32'(rv_o[g]), 32'(m_rv));
        check(bv_o[g] === m_bv, "R2/R3 write strobe", g, 32'(bv_o[g]), 32'(m_bv));
        check(rsp_o[g] === m_rsp[g], "R6/R7/R8 response", g, 32'(rsp_o[g]), 32'(m_rsp[g]));
        check(rd_o[g] === m_rd, "R4/R10 read data", g, rd_o[g], m_rd);
        check(ctrl_o[g] === m_ctrl, "R5/R9 control word", g, ctrl_o[g], m_ctrl);
        check(cmd_o[g] === m_cmd, "R4/R9 command word", g, cmd_o[g], m_cmd);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input bit w, input bit r, input int byte_addr,
                      input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_i = w; rd_i = r; addr_i = 4'(byte_addr >> 2); wdata_i = d; be_i = be;
    while (wait_o[0]) @(negedge clk);
    @(negedge clk);
    wr_i = 0; rd_i = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    xfer(1, 0, a, d, be);
  endtask

  task automatic rd(input int a);
    xfer(0, 1, a, '0, '0);
  endtask

  task automatic reset_check();
    for (int g = 0; g < 4; g++) begin
      check(rv_o[g] === 0 && bv_o[g] === 0, "R11 strobes after reset", g,
            {30'd0, rv_o[g], bv_o[g]}, 32'd0);
      check(wait_o[g] === 0 && rsp_o[g] === 2'b00, "R11 stall/code after reset", g,
            {29'd0, wait_o[g], rsp_o[g]}, 32'd0);
      check(ctrl_o[g] === 0 && cmd_o[g] === 0, "R11 words after reset", g,
            ctrl_o[g] | cmd_o[g], 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    reset_check();
    live = 1;

    wr(32'h00, 32'hA5A5_1234, 4'hF);          // R4 control word
    rd(32'h00);
    wr(32'h04, 32'hDEAD_BEEF, 4'b0101);       // R5 lanes 0 and 2
    rd(32'h04);
    wr(32'h04, 32'h1111_1111, 4'b0000);       // R5 no lanes
    rd(32'h04);
    wr(32'h10, 32'h1122_3344, 4'hF);          // R4 command word
    rd(32'h10);                               // R8/R10 read of write-only
    wr(32'h08, 32'hFFFF_FFFF, 4'hF);          // R8/R9 write to status
    wr(32'h0C, 32'hFFFF_FFFF, 4'hF);          // R8/R9 write to identity
    rd(32'h08);
    status_i = 32'h7777_0042;
    rd(32'h08);
    rd(32'h0C);
    wr(32'h1C, 32'hCAFE_CAFE, 4'hF);          // R7/R9 unmapped write
    rd(32'h3C);                               // R7/R10 unmapped read
    rd(32'h14);
    xfer(1, 1, 32'h04, 32'h0F0F_0F0F, 4'hF);  // R3 both strobes -> write
    rd(32'h04);

    // R1 request held across the stall cycle: two accepted reads
    @(negedge clk);
    rd_i = 1; addr_i = 4'd0;
    repeat (4) @(negedge clk);
    wr_i = 1; rd_i = 0; addr_i = 4'd4; wdata_i = 32'h0000_BEEF; be_i = 4'b0011;
    repeat (4) @(negedge clk);
    wr_i = 0;
    @(negedge clk);

    for (int i = 0; i < 60; i++) begin
      int a;
      a = ((i * 7) % 16) * 4;
      status_i = status_i * 32'd1103515245 + 32'd12345;
      if (i % 3 == 0) rd(a);
      else wr(a, status_i ^ 32'h3C3C_5A5A, 4'(i * 5));
    end

    // R11 reset after traffic
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    reset_check();
    rd(32'h00);
    rd(32'h04);
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule